// File: doc/BRIEF.md
# Lock-bit command window for self-programming control

This block guards the lock-bit path of a microcontroller's self-programming control register. Software arms a lock-bit operation by writing one specific code to the control register. That write sets two enable bits: a lock-select enable and a store enable. While the enables are set, the block counts clock cycles. It accepts a store-program strobe for a short window and a load-program strobe for a window one cycle longer. An accepted store programs lock bits from the store data byte. An accepted load returns the lock bits on the read-data port in place of the program-memory data.

The enables clear themselves as soon as an operation is accepted, or when the load window runs out. Lock bits read 1 when unprogrammed and 0 when programmed. Programming only moves a bit from 1 to 0, and only a reset restores it to 1. When the block is not armed, a load simply passes the program-memory read data through.

Cycle k after the arming write is the cycle whose strobe is sampled at the k-th rising edge after the edge that captured the write.

Top module: `lock_cmd_window`

## Requirements
- R1: After reset the enables are clear, so `ctrl_rdata_o` reads 0x00 and `lock_o` reads 4'b1111, meaning all lock bits are unprogrammed.
- R2: A control write of exactly 0x09 arms the block. From the next cycle `ctrl_rdata_o` reads 0x09, which is bit 3 (lock-select enable) plus bit 0 (store enable). A write of any other value clears both enables, and the register then reads 0x00.
- R3: A store strobe in cycles 1 to 4 after the arming write programs lock bits. Data bits 5, 4, 3 and 2 drive `lock_o[3]`, `lock_o[2]`, `lock_o[1]` and `lock_o[0]`, and a 0 in one of those positions clears the matching bit from the next cycle.
- R4: A store strobe in cycle 5 or later after arming, or one that arrives while the block is not armed, leaves `lock_o` unchanged.
- R5: A load strobe with `ptr_i` equal to 0x0001 in cycles 1 to 5 while armed makes `rdata_o` equal {2'b11, `lock_o`, 2'b11} in that same cycle.
- R6: A load while not armed, or a load with `ptr_i` other than 0x0001, makes `rdata_o` equal `flash_rdata_i`.
- R7: An accepted store, or an accepted lock-bit load, clears both enables from the next cycle.
- R8: If no operation is accepted, the enables stay set through cycle 5 and read 0x00 from cycle 6 on.
- R9: A 1 in a data-byte position never sets a lock bit back to 1. A bit that has been programmed stays 0 until reset.
- R10: Every control write restarts the cycle count, so re-arming with 0x09 opens a full new store window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read value (enable bits) |
| store_i | input | 1 | Store-program instruction strobe |
| load_i | input | 1 | Load-program instruction strobe |
| ptr_i | input | 16 | Address pointer used by a load |
| data_i | input | 8 | Store data byte |
| flash_rdata_i | input | 8 | Ordinary program-memory read data |
| rdata_o | output | 8 | Load result |
| lock_o | output | 4 | Lock-bit storage, 0 = programmed |

## Verification
The assertions take two things for granted. The strobes and the control write are single-cycle pulses sampled at the rising edge, and a store and a load never arrive in the same cycle. The bench drives every input on the falling edge and issues at most one strobe per cycle. It never puts a strobe in the same cycle as a control write, so the cycle count that each check relies on always starts from one known arming edge.

// File: rtl/lock_cmd_pkg.sv
package lock_cmd_pkg;
  localparam int unsigned STORE_WIN = 4;
  localparam int unsigned LOAD_WIN  = 5;
  localparam int unsigned N_LOCK    = 4;
  localparam int unsigned LOCK_LSB  = 2;
  localparam int unsigned PTR_W     = 16;
  localparam logic [7:0]  ARM_CODE  = 8'h09;
  localparam int unsigned SEL_BIT   = 3;
  localparam int unsigned ST_BIT    = 0;

  function automatic logic [7:0] pack_locks(input logic [N_LOCK-1:0] l);
    logic [7:0] b;
    b = 8'hFF;
    b[LOCK_LSB +: N_LOCK] = l;
    return b;
  endfunction
endpackage

// File: rtl/lock_window_timer.sv
module lock_window_timer #(
  parameter int unsigned STORE_WIN = 4,
  parameter int unsigned LOAD_WIN  = 5,
  parameter logic [7:0]  ARM_CODE  = 8'h09
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic [7:0] wdata_i,
  input  logic store_i,
  input  logic load_hit_i,
  output logic armed_o,
  output logic store_ok_o,
  output logic load_ok_o
);
  localparam int unsigned AGE_W = $clog2(LOAD_WIN + 1);
  localparam logic [AGE_W-1:0] AGE_ST = AGE_W'(STORE_WIN);
  localparam logic [AGE_W-1:0] AGE_LD = AGE_W'(LOAD_WIN);

  logic             armed_q;
  logic [AGE_W-1:0] age_q;
  logic             done;

  assign store_ok_o = armed_q && store_i && (age_q <= AGE_ST);
  assign load_ok_o  = armed_q && load_hit_i && (age_q <= AGE_LD);
  assign done       = store_ok_o || load_ok_o;
  assign armed_o    = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (we_i) begin
      armed_q <= (wdata_i == ARM_CODE);
      age_q   <= (wdata_i == ARM_CODE) ? AGE_W'(1) : '0;
    end else if (armed_q) begin
      if (done || age_q == AGE_LD) begin
        armed_q <= 1'b0;
        age_q   <= '0;
      end else begin
        age_q <= age_q + AGE_W'(1);
      end
    end
  end

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i == ARM_CODE |=> armed_q && age_q == AGE_W'(1));
  p_disarm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i != ARM_CODE |=> !armed_q);
  p_clear_on_use_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && (store_ok_o || load_ok_o) |=> !armed_q);
  p_timeout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && armed_q && age_q == AGE_LD |=> !armed_q);
  p_age_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> age_q >= AGE_W'(1) && age_q <= AGE_LD);
endmodule

// File: rtl/lock_bit_store.sv
module lock_bit_store #(
  parameter int unsigned N_LOCK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [N_LOCK-1:0] mask_i,
  output logic [N_LOCK-1:0] lock_o
);
  logic [N_LOCK-1:0] lock_q;

  for (genvar g = 0; g < N_LOCK; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  lock_q[g] <= 1'b1;
      else if (prog_i && !mask_i[g]) lock_q[g] <= 1'b0;
    end
  end

  assign lock_o = lock_q;

  p_no_unprogram_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lock_q & ~$past(lock_q)) == '0);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |=> $stable(lock_q));
  p_prog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> lock_q == ($past(lock_q) & $past(mask_i)));
endmodule

// File: rtl/lock_read_mux.sv
module lock_read_mux
  import lock_cmd_pkg::*;
(
  input  logic              sel_lock_i,
  input  logic [N_LOCK-1:0] lock_i,
  input  logic [7:0]        flash_rdata_i,
  output logic [7:0]        rdata_o
);
  always_comb begin
    if (sel_lock_i) rdata_o = pack_locks(lock_i);
    else            rdata_o = flash_rdata_i;
  end

  always_comb begin
    if (sel_lock_i) p_lock_read_r5: assert (rdata_o[LOCK_LSB +: N_LOCK] == lock_i);
  end
endmodule

// File: rtl/lock_cmd_window.sv
module lock_cmd_window
  import lock_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic              store_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        flash_rdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_LOCK-1:0] lock_o
);
  localparam logic [PTR_W-1:0] LOCK_PTR = PTR_W'(1);

  logic armed, store_ok, load_ok, load_hit;
  logic unused_data;

  assign load_hit    = load_i && (ptr_i == LOCK_PTR);
  assign unused_data = ^{data_i[7:LOCK_LSB+N_LOCK], data_i[LOCK_LSB-1:0]};

  lock_window_timer #(
    .STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN), .ARM_CODE(ARM_CODE)
  ) i_timer (
    .clk_i, .rst_ni,
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .store_i    (store_i),
    .load_hit_i (load_hit),
    .armed_o    (armed),
    .store_ok_o (store_ok),
    .load_ok_o  (load_ok)
  );

  lock_bit_store #(.N_LOCK(N_LOCK)) i_store (
    .clk_i, .rst_ni,
    .prog_i (store_ok),
    .mask_i (data_i[LOCK_LSB +: N_LOCK]),
    .lock_o (lock_o)
  );

  lock_read_mux i_mux (
    .sel_lock_i    (load_ok),
    .lock_i        (lock_o),
    .flash_rdata_i (flash_rdata_i),
    .rdata_o       (rdata_o)
  );

  always_comb begin
    ctrl_rdata_o          = '0;
    ctrl_rdata_o[SEL_BIT] = armed;
    ctrl_rdata_o[ST_BIT]  = armed;
  end

  p_passthru_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ptr_i != LOCK_PTR |-> rdata_o == flash_rdata_i);
  p_idle_ctrl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> ctrl_rdata_o == 8'h00);
endmodule

// File: tb/test_lock_cmd_window.sv
module test_lock_cmd_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  crd;
  logic        st = 1'b0, ld = 1'b0;
  logic [15:0] ptr = '0;
  logic [7:0]  data = 8'hFF;
  logic [7:0]  frd = 8'hA5;
  logic [7:0]  rd;
  logic [3:0]  lock;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lock_cmd_window i_lock_cmd_window (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(crd), .store_i(st), .load_i(ld), .ptr_i(ptr),
    .data_i(data), .flash_rdata_i(frd), .rdata_o(rd), .lock_o(lock)
  );

  typedef struct packed {
    logic [2:0]  k;
    logic        is_load;
    logic [7:0]  data;
    logic [15:0] ptr;
    logic [7:0]  exp_rd;
    logic [3:0]  exp_lock;
    logic [7:0]  exp_ctrl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 8'hC3, 16'h0001, 8'hA5, 4'b0000, 8'h00},  // R3 all programmed
    '{3'd4, 1'b0, 8'hFB, 16'h0001, 8'hA5, 4'b1110, 8'h00},  // R3 last store cycle
    '{3'd5, 1'b0, 8'h00, 16'h0001, 8'hA5, 4'b1111, 8'h00},  // R4 too late
    '{3'd6, 1'b0, 8'h00, 16'h0001, 8'hA5, 4'b1111, 8'h00},  // R4 expired
    '{3'd2, 1'b0, 8'hDF, 16'h0001, 8'hA5, 4'b0111, 8'h00},  // R3 bit5 -> lock[3]
    '{3'd5, 1'b1, 8'hFF, 16'h0001, 8'hFF, 4'b1111, 8'h00},  // R5 last load cycle
    '{3'd1, 1'b1, 8'hFF, 16'h0002, 8'hA5, 4'b1111, 8'h09},  // R6 wrong pointer
    '{3'd6, 1'b1, 8'hFF, 16'h0001, 8'hA5, 4'b1111, 8'h00},  // R6 load after expiry
    '{3'd3, 1'b0, 8'hF7, 16'h0001, 8'hA5, 4'b1101, 8'h00}   // R3 bit3 -> lock[1]
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; st = 1'b0; ld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // leaves the bench in cycle 1 after the write
  task automatic ctrl_write(input logic [7:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic strobe(input logic is_load, input logic [7:0] d, input logic [15:0] p);
    st = !is_load; ld = is_load; data = d; ptr = p;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R1 ctrl after reset", crd, 8'h00);
    check("R1 lock after reset", {4'h0, lock}, 8'h0F);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      ctrl_write(8'h09);
      repeat (int'(VECS[i].k) - 1) @(negedge clk);
      strobe(VECS[i].is_load, VECS[i].data, VECS[i].ptr);
      check($sformatf("R5/R6 vec%0d rdata", i), rd, VECS[i].exp_rd);
      @(negedge clk);
      st = 1'b0; ld = 1'b0;
      #1;
      check($sformatf("R3/R4 vec%0d lock", i), {4'h0, lock}, {4'h0, VECS[i].exp_lock});
      check($sformatf("R7/R8 vec%0d ctrl", i), crd, VECS[i].exp_ctrl);
    end

    // R2: arm code and other codes
    do_reset();
    @(negedge clk);
    ctrl_write(8'h09); #1;
    check("R2 armed read", crd, 8'h09);
    @(negedge clk);
    ctrl_write(8'h01); #1;
    check("R2 other code disarms", crd, 8'h00);
    strobe(1'b0, 8'h00, 16'h0001);
    @(negedge clk); st = 1'b0; #1;
    check("R4 store unarmed", {4'h0, lock}, 8'h0F);

    // R8: timeout edge
    ctrl_write(8'h09);
    repeat (4) @(negedge clk);
    #1 check("R8 still armed in cycle 5", crd, 8'h09);
    @(negedge clk); #1;
    check("R8 cleared in cycle 6", crd, 8'h00);

    // R9 and R5 with programmed bits
    ctrl_write(8'h09);
    strobe(1'b0, 8'hEB, 16'h0001);   // bits5..2 = 1010
    @(negedge clk); st = 1'b0;
    ctrl_write(8'h09);
    strobe(1'b0, 8'hFF, 16'h0001);
    @(negedge clk); st = 1'b0; #1;
    check("R9 ones do not unprogram", {4'h0, lock}, 8'h0A);
    ctrl_write(8'h09);
    strobe(1'b1, 8'hFF, 16'h0001);
    check("R5 lock byte read", rd, 8'hEB);
    @(negedge clk); ld = 1'b0; #1;
    check("R7 load clears enables", crd, 8'h00);
    strobe(1'b1, 8'hFF, 16'h0001);
    check("R6 load after completion", rd, 8'hA5);
    @(negedge clk); ld = 1'b0;

    // R10: re-arm restarts the window
    do_reset();
    @(negedge clk);
    ctrl_write(8'h09);
    repeat (2) @(negedge clk);
    ctrl_write(8'h09);
    repeat (3) @(negedge clk);
    strobe(1'b0, 8'hEF, 16'h0001);  // bit4 = 0
    @(negedge clk); st = 1'b0; #1;
    check("R10 rearm reopens window", {4'h0, lock}, 8'h0B);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule